// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the clocks for a stereo audio serial port from a single fast input clock: an optional master clock, the serial bit clock, and the word-select (frame) signal. The divide ratio is set by an 8-bit half-divider field plus an extra odd bit, so the input clock is divided by twice the field plus the odd bit. A zero ratio passes the input clock straight through. The one combination that would need a divide-by-three is rejected and flagged.

When the master clock output is off, the divided clock is the bit clock itself. A frame is 32 or 64 bit clocks for the standard formats, selected by a channel-length bit, and half that in the short-frame (DSP/PCM) format. When the master clock output is on, the divided clock leaves as the master clock. The bit clock is then a further division of it by 8 or 4, so that a frame always lasts 256 master clocks in standard formats and 128 in DSP format. Settings are sampled while the block is stopped, and while it runs they are taken over only at a frame boundary. A hold option keeps the clock pins driven at their idle level while the port is stopped.

All state is clocked by the input clock, with a synchronous active-high reset. Timing is counted in input clock cycles; a "sample" below is one cycle.

Top module: `aclk_gen`

## Requirements
- R1: With effective ratio N = 2*`cfg_div` + `cfg_odd` and N >= 2, the divided clock has a period of N input cycles. It is high for ceil(N/2) cycles and low for floor(N/2), so on odd ratios the high phase is one cycle longer.
- R2: When N is 0 or 1 (`cfg_div` = 0), the divided clock is the input clock itself: high while `clk` is high and low while it is low.
- R3: `cfg_div` = 1 with `cfg_odd` = 1 is illegal. `cfg_err_o` is high in the cycle after that setting is on the inputs, and low otherwise. While an illegal setting is the active one, `mclk_o`, `bclk_o` and `ws_o` stay low. A legal setting applied later starts the clocks.
- R4: With `cfg_mclk_en` = 0, `bclk_o` is the divided clock and `mclk_o` is low. In standard format (`cfg_dsp` = 0) a frame is 32 bit clocks when `cfg_wide` = 0 and 64 when it is 1. `ws_o` is high for the first half of each frame and rises at frame start.
- R5: In DSP format (`cfg_dsp` = 1) a frame is 16 bit clocks (`cfg_wide` = 0) or 32 (`cfg_wide` = 1). `ws_o` is high for exactly one bit-clock period at frame start.
- R6: With `cfg_mclk_en` = 1, `mclk_o` is the divided clock. `bclk_o` is `mclk_o` divided by 8 when `cfg_wide` = 0 and by 4 when it is 1, high for the first half of its period. A frame therefore lasts 256 master clocks in standard format and 128 in DSP format.
- R7: `pins_oe_o` is high whenever the clocks are running or `cfg_hold` is 1. When the clocks are not running, `bclk_o`, `ws_o` and `mclk_o` are low.
- R8: A setting changed while running takes effect at the next frame start (the next rise of `ws_o`). The current frame finishes with the old ratio.
- R9: After reset and while `en` is low, all outputs are low. Raising `en` starts a frame in the cycle after `en` is sampled, so `ws_o` is high in that cycle. Lowering `en` stops all clocks in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (kernel) clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| cfg_div | input | 8 | Half-divider field |
| cfg_odd | input | 1 | Adds one to the ratio |
| cfg_mclk_en | input | 1 | Master clock output enable |
| cfg_wide | input | 1 | Channel length: 0 short, 1 long |
| cfg_dsp | input | 1 | Short-frame (DSP/PCM) format |
| cfg_hold | input | 1 | Drive pins at idle level while stopped |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select / frame sync |
| pins_oe_o | output | 1 | Output drive enable for the clock pins |
| cfg_err_o | output | 1 | Illegal divider setting flag |

## Verification
Six settings are run through the same measurement of clock high time, period, bit period, frame length and word-select width. Even and odd ratios separate the ceiling split of the phases. Short and long channels, standard and DSP formats separate the four frame lengths. Master-clock settings show whether the bit clock divider switches between 8 and 4 with channel length independently of the format. Directed runs cover the pass-through ratio against both clock levels, the forbidden setting and recovery from it, a mid-frame ratio change that must not affect the frame in progress, the idle hold option, and start and stop.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  // Frame-shape selection kept together so it is latched as one unit.
  typedef struct packed {
    logic mclk_en;
    logic wide;
    logic dsp;
  } aclk_mode_t;

  localparam aclk_mode_t MODE_IDLE = '{mclk_en: 1'b0, wide: 1'b0, dsp: 1'b0};

endpackage

// File: rtl/aclk_div.sv
// Fractional-free divider: ratio = {div, odd}; zero collapses to one.
module aclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic             odd,
  output logic             lvl,
  output logic             tick,
  output logic             bypass,
  output logic [DIV_W:0]   cnt_o,
  output logic [DIV_W:0]   ratio_o
);

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] raw, eff, hi, cnt;

  always_comb begin
    raw    = {div, odd};
    eff    = (raw == '0) ? CNT_W'(1) : raw;
    hi     = (eff >> 1) + CNT_W'(eff[0]);
    tick   = run && (cnt == eff - CNT_W'(1));
    lvl    = run && (cnt < hi);
    bypass = (eff == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign cnt_o   = cnt;
  assign ratio_o = eff;

endmodule

// File: rtl/aclk_frame.sv
// Bit-clock sub-divider (master-clock mode) and frame / word-select counter.
module aclk_frame #(
  parameter int FRAME_BASE = 32,
  parameter int MCLK_RATIO = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic div_tick,
  input  logic mclk_en,
  input  logic wide,
  input  logic dsp,
  output logic sub_lvl,
  output logic bit_tick,
  output logic frame_end,
  output logic ws
);

  localparam int SUB_MAX = MCLK_RATIO / FRAME_BASE;
  localparam int SUB_W   = $clog2(SUB_MAX) + 1;
  localparam int BIT_W   = $clog2(2 * FRAME_BASE) + 1;

  logic [SUB_W-1:0] sub, m;
  logic [BIT_W-1:0] bitc, fb;
  logic             sub_end;

  always_comb begin
    m        = wide ? SUB_W'(SUB_MAX / 2) : SUB_W'(SUB_MAX);
    sub_end  = div_tick && (sub == m - SUB_W'(1));
    bit_tick = mclk_en ? sub_end : div_tick;
    if (dsp) fb = wide ? BIT_W'(FRAME_BASE)     : BIT_W'(FRAME_BASE / 2);
    else     fb = wide ? BIT_W'(2 * FRAME_BASE) : BIT_W'(FRAME_BASE);
    frame_end = bit_tick && (bitc == fb - BIT_W'(1));
    sub_lvl   = run && (sub < (m >> 1));
    ws        = run && (dsp ? (bitc == '0) : (bitc < (fb >> 1)));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sub  <= '0;
      bitc <= '0;
    end else begin
      if (mclk_en && div_tick) sub  <= sub_end ? '0 : sub + SUB_W'(1);
      if (bit_tick)            bitc <= frame_end ? '0 : bitc + BIT_W'(1);
    end
  end

endmodule

// File: rtl/aclk_gen.sv
module aclk_gen #(
  parameter int DIV_W      = 8,
  parameter int FRAME_BASE = 32,
  parameter int MCLK_RATIO = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_odd,
  input  logic             cfg_mclk_en,
  input  logic             cfg_wide,
  input  logic             cfg_dsp,
  input  logic             cfg_hold,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             pins_oe_o,
  output logic             cfg_err_o
);
  import aclk_pkg::*;

  logic [DIV_W-1:0] act_div;
  logic             act_odd;
  aclk_mode_t       act_mode;
  logic             on, err_q, bad_act, run;
  logic             dlvl, div_tick, bypass, divclk;
  logic             sub_lvl, bit_tick, frame_end, ws;
  logic [DIV_W:0]   div_cnt, eff_ratio;

  assign bad_act = (act_div == DIV_W'(1)) && act_odd;
  assign run     = on && !bad_act;

  // Settings follow the inputs while stopped; while running only at frame end.
  always_ff @(posedge clk) begin
    if (rst) begin
      on       <= 1'b0;
      err_q    <= 1'b0;
      act_div  <= '0;
      act_odd  <= 1'b0;
      act_mode <= MODE_IDLE;
    end else begin
      on    <= en;
      err_q <= (cfg_div == DIV_W'(1)) && cfg_odd;
      if (!run || frame_end) begin
        act_div  <= cfg_div;
        act_odd  <= cfg_odd;
        act_mode <= '{mclk_en: cfg_mclk_en, wide: cfg_wide, dsp: cfg_dsp};
      end
    end
  end

  aclk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .div     (act_div),
    .odd     (act_odd),
    .lvl     (dlvl),
    .tick    (div_tick),
    .bypass  (bypass),
    .cnt_o   (div_cnt),
    .ratio_o (eff_ratio)
  );

  aclk_frame #(.FRAME_BASE(FRAME_BASE), .MCLK_RATIO(MCLK_RATIO)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .div_tick  (div_tick),
    .mclk_en   (act_mode.mclk_en),
    .wide      (act_mode.wide),
    .dsp       (act_mode.dsp),
    .sub_lvl   (sub_lvl),
    .bit_tick  (bit_tick),
    .frame_end (frame_end),
    .ws        (ws)
  );

  always_comb begin
    divclk    = bypass ? clk : dlvl;
    mclk_o    = (run && act_mode.mclk_en) ? divclk : 1'b0;
    if (!run)                 bclk_o = 1'b0;
    else if (act_mode.mclk_en) bclk_o = sub_lvl;
    else                      bclk_o = divclk;
    ws_o      = ws;
    pins_oe_o = run || cfg_hold;
    cfg_err_o = err_q;
  end

endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [DIV_W-1:0] cfg_div,
  input logic             cfg_odd,
  input logic             ws_o,
  input logic             pins_oe_o,
  input logic             cfg_err_o,
  input logic             run,
  input logic             bit_tick,
  input logic [DIV_W:0]   div_cnt,
  input logic [DIV_W:0]   eff_ratio
);

  // R9
  en_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !ws_o);

  // R7
  oe_when_ws_chk: assert property (@(posedge clk) disable iff (rst)
    ws_o |-> pins_oe_o);

  // R3
  err_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_err_o) |-> $past((cfg_div == DIV_W'(1)) && cfg_odd));

  // R8
  ws_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(ws_o)) |-> $past(bit_tick));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (div_cnt < eff_ratio));

endmodule

bind aclk_gen aclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .cfg_div   (cfg_div),
  .cfg_odd   (cfg_odd),
  .ws_o      (ws_o),
  .pins_oe_o (pins_oe_o),
  .cfg_err_o (cfg_err_o),
  .run       (run),
  .bit_tick  (bit_tick),
  .div_cnt   (div_cnt),
  .eff_ratio (eff_ratio)
);

// File: tb/sim_aclk_gen.sv
module sim_aclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 4000;
  localparam int NV         = 6;
  // div, odd, mclk_en, wide, dsp, exp_hi, exp_per, exp_bper, exp_frame, exp_ws_hi
  localparam int TBL [0:NV-1][0:9] = '{
    '{2, 0, 0, 0, 0, 2, 4,  4, 128,  64},
    '{2, 1, 0, 0, 0, 3, 5,  5, 160,  80},
    '{3, 1, 0, 1, 0, 4, 7,  7, 448, 224},
    '{2, 0, 0, 0, 1, 2, 4,  4,  64,   4},
    '{1, 0, 1, 0, 0, 1, 2, 16, 512, 256},
    '{3, 0, 1, 1, 1, 3, 6, 24, 768,  24}
  };

  logic       clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [7:0] cfg_div = '0;
  logic       cfg_odd = 1'b0, cfg_mclk_en = 1'b0, cfg_wide = 1'b0;
  logic       cfg_dsp = 1'b0, cfg_hold = 1'b0;
  logic       mclk_o, bclk_o, ws_o, pins_oe_o, cfg_err_o;
  int         tests = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  aclk_gen u0 (
    .clk(clk), .rst(rst), .en(en), .cfg_div(cfg_div), .cfg_odd(cfg_odd),
    .cfg_mclk_en(cfg_mclk_en), .cfg_wide(cfg_wide), .cfg_dsp(cfg_dsp),
    .cfg_hold(cfg_hold), .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o),
    .pins_oe_o(pins_oe_o), .cfg_err_o(cfg_err_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input int s);
    case (s)
      0:       return mclk_o;
      1:       return bclk_o;
      default: return ws_o;
    endcase
  endfunction

  // Waits for a rising sample of the chosen output, then measures one
  // full period and the number of high samples in it.
  task automatic meas(input int s, output int hi, output int per);
    logic prev;
    bit   found = 0;
    hi = -1;
    per = -1;
    for (int i = 0; i < LIM && !found; i++) begin
      prev = pick(s);
      step();
      if (!prev && pick(s)) found = 1;
    end
    if (found) begin
      int h = 1, p = 1;
      found = 0;
      for (int i = 0; i < LIM && !found; i++) begin
        prev = pick(s);
        step();
        if (!prev && pick(s)) found = 1;
        else begin
          p++;
          if (pick(s)) h++;
        end
      end
      if (found) begin
        hi = h;
        per = p;
      end
    end
  endtask

  task automatic setup(input int d, input int o, input int m, input int w, input int p);
    en = 1'b0;
    step();
    cfg_div = 8'(d);
    cfg_odd = 1'(o);
    cfg_mclk_en = 1'(m);
    cfg_wide = 1'(w);
    cfg_dsp = 1'(p);
    step();
    en = 1'b1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int h, p, quiet;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R9 reset state
    chk(mclk_o, 0, "R9 mclk after reset");
    chk(bclk_o, 0, "R9 bclk after reset");
    chk(ws_o, 0, "R9 ws after reset");
    chk(cfg_err_o, 0, "R3 err after reset");
    chk(pins_oe_o, 0, "R7 oe after reset");

    // Table of settings
    for (int v = 0; v < NV; v++) begin
      setup(TBL[v][0], TBL[v][1], TBL[v][2], TBL[v][3], TBL[v][4]);
      step();
      chk(ws_o, 1, "R9 ws high in first running cycle");
      meas(TBL[v][2] ? 0 : 1, h, p);
      chk(h, TBL[v][5], "R1 divided clock high time");
      chk(p, TBL[v][6], "R1 divided clock period");
      if (TBL[v][2] == 0) chk(mclk_o, 0, "R4 mclk low when disabled");
      meas(1, h, p);
      chk(p, TBL[v][7], TBL[v][2] ? "R6 bit clock period" : "R4 bit clock period");
      meas(2, h, p);
      chk(p, TBL[v][8], TBL[v][4] ? "R5 frame length" : "R4 frame length");
      chk(h, TBL[v][9], TBL[v][4] ? "R5 ws width" : "R4 ws width");
    end

    // R2 pass-through ratio
    setup(0, 0, 0, 0, 0);
    step();
    step();
    chk(bclk_o, 1, "R2 bypass follows clk high");
    @(negedge clk);
    #1;
    chk(bclk_o, 0, "R2 bypass follows clk low");
    meas(2, h, p);
    chk(p, 32, "R2 bypass frame length");
    setup(0, 1, 1, 1, 0);
    step();
    step();
    chk(mclk_o, 1, "R2 mclk bypass high");
    @(negedge clk);
    #1;
    chk(mclk_o, 0, "R2 mclk bypass low");
    meas(1, h, p);
    chk(p, 4, "R6 bit clock over bypass master clock");

    // R3 forbidden setting
    setup(1, 1, 0, 0, 0);
    step();
    chk(cfg_err_o, 1, "R3 error flag raised");
    quiet = 1;
    for (int i = 0; i < 60; i++) begin
      step();
      if (bclk_o || ws_o || mclk_o) quiet = 0;
    end
    chk(quiet, 1, "R3 outputs quiet on illegal setting");
    cfg_odd = 1'b0;
    cfg_div = 8'd2;
    step();
    chk(cfg_err_o, 0, "R3 error flag cleared");
    meas(1, h, p);
    chk(p, 4, "R3 recovery bit period");

    // R8 change mid-frame
    setup(2, 0, 0, 0, 0);
    step();
    repeat (10) step();
    cfg_div = 8'd3;
    meas(1, h, p);
    chk(p, 4, "R8 old ratio holds in current frame");
    meas(2, h, p);
    chk(p, 192, "R8 new ratio from next frame");

    // R9 stop and R7 idle hold
    en = 1'b0;
    step();
    chk(ws_o | bclk_o | mclk_o, 0, "R9 outputs stop after en low");
    chk(pins_oe_o, 0, "R7 pins released when idle");
    cfg_hold = 1'b1;
    step();
    chk(pins_oe_o, 1, "R7 pins driven when hold set");
    chk(bclk_o | ws_o, 0, "R7 held pins at idle level");

    summary();
    $finish;
  end
endmodule